// File: doc/BRIEF.md
# Poisoned Register File for Deferred Speculative Faults

This block is a register file in which every register carries one extra poison flag. The flag marks a value that a speculatively hoisted instruction could not produce. The issue stage tags each instruction as speculative or normal. When a speculative instruction hits a fatal-class fault, such as a protection violation, it does not trap. Its result slot is written with a zeroed payload and the poison flag set. When a speculative instruction consumes a poisoned source, it passes the poison on to its own destination.

The fault is raised only when the poisoned value reaches a committed consumer. A normal instruction that reads a poisoned register through either read port raises an exception, and the block reports which register caused it. A check instruction, placed where the hoisted instruction originally stood, can test any register. If that register is poisoned, the block requests a redirect to recovery code. Resumable faults such as page faults are serviced elsewhere and never reach the fault input. Any clean write clears the poison flag.

Top module: `natreg_file`

## Requirements
- R1: After reset every register reads data 0 with its poison flag clear, and neither the exception nor the redirect output is asserted.
- R2: A write with `wr_spec`=0 and `wr_fault`=0 stores `wr_data` and clears the poison flag of the destination from the next cycle on.
- R3: A write with `wr_spec`=1 and `wr_fault`=1 sets the destination's poison flag and stores data 0.
- R4: A write with `wr_spec`=1, `wr_fault`=0 and `wr_src_nat`=1 sets the destination's poison flag and stores data 0. With `wr_src_nat`=0 it behaves as a clean write.
- R5: A write with `wr_spec`=0 and `wr_fault`=1 is a trapping fault. It leaves both the data and the poison flag of the destination unchanged.
- R6: When `rd_spec`=0 and an enabled read port addresses a poisoned register, `exc_o` is 1 in that same cycle and `exc_addr_o` holds that register's index.
- R7: When `rd_spec`=1, reading a poisoned register never asserts `exc_o`. The poison flag still appears on that port's `rd_x_nat` output.
- R8: When both enabled ports see poisoned registers on a normal read, one exception is reported and `exc_addr_o` holds port A's address.
- R9: A read port whose enable is 0 never causes an exception, whatever register it addresses.
- R10: `recover_o` is 1 exactly when `chk_en`=1 and the register at `chk_addr` is poisoned.
- R11: Reads are combinational. A write becomes visible only after the clock edge that accepts it, so a read in the same cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_en | input | 1 | Port A read is in use by the instruction |
| rd_a_addr | input | AW | Port A register index |
| rd_a_data | output | XLEN | Port A data |
| rd_a_nat | output | 1 | Port A poison flag |
| rd_b_en | input | 1 | Port B read is in use by the instruction |
| rd_b_addr | input | AW | Port B register index |
| rd_b_data | output | XLEN | Port B data |
| rd_b_nat | output | 1 | Port B poison flag |
| rd_spec | input | 1 | The reading instruction is speculative |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Destination index |
| wr_data | input | XLEN | Result data |
| wr_spec | input | 1 | The writing instruction is speculative |
| wr_fault | input | 1 | The writing instruction hit a fatal-class fault |
| wr_src_nat | input | 1 | A source of the writing instruction was poisoned |
| chk_en | input | 1 | Check instruction present |
| chk_addr | input | AW | Register tested by the check |
| exc_o | output | 1 | Deferred exception raised by a normal consumer |
| exc_addr_o | output | AW | Register that caused the exception |
| recover_o | output | 1 | Redirect to recovery code |

## Verification
The assertions watch the write side on every cycle. A faulting or propagating speculative write must leave a poisoned, zeroed register, a clean write must leave a clear flag, and a trapping normal fault must leave the register untouched. They also check that speculative readers never raise, that port A wins the exception report, and that a disabled port stays silent. Only the bench scenarios show the whole sequence end to end: a value poisoned, then read speculatively, then caught by a check or a normal read, then cleaned by a later write. The bench also covers the same-cycle read-before-write behaviour.

// File: rtl/natreg_file.sv
module natreg_file #(
  parameter int NREG = 32,
  parameter int XLEN = 64,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_a_en,
  input  logic [AW-1:0]   rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  output logic            rd_a_nat,
  input  logic            rd_b_en,
  input  logic [AW-1:0]   rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  output logic            rd_b_nat,
  input  logic            rd_spec,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            wr_spec,
  input  logic            wr_fault,
  input  logic            wr_src_nat,
  input  logic            chk_en,
  input  logic [AW-1:0]   chk_addr,
  output logic            exc_o,
  output logic [AW-1:0]   exc_addr_o,
  output logic            recover_o
);

  logic [XLEN-1:0] data_q [NREG];
  logic [NREG-1:0] nat_q;

  // a normal instruction that faults traps instead of writing
  wire wr_commit = wr_en & (wr_spec | ~wr_fault);
  wire wr_poison = wr_spec & (wr_fault | wr_src_nat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) data_q[i] <= '0;
      nat_q <= '0;
    end else if (wr_commit) begin
      data_q[wr_addr] <= wr_poison ? '0 : wr_data;
      nat_q[wr_addr]  <= wr_poison;
    end
  end

  assign rd_a_data = data_q[rd_a_addr];
  assign rd_a_nat  = nat_q[rd_a_addr];
  assign rd_b_data = data_q[rd_b_addr];
  assign rd_b_nat  = nat_q[rd_b_addr];

  wire hit_a = rd_a_en & rd_a_nat & ~rd_spec;
  wire hit_b = rd_b_en & rd_b_nat & ~rd_spec;

  assign exc_o      = hit_a | hit_b;
  assign exc_addr_o = hit_a ? rd_a_addr : rd_b_addr;
  assign recover_o  = chk_en & nat_q[chk_addr];

  a_r3_fault_poisons: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en & wr_spec & wr_fault |=> nat_q[$past(wr_addr)] && data_q[$past(wr_addr)] == '0);

  a_r4_poison_spreads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en & wr_spec & wr_src_nat |=> nat_q[$past(wr_addr)]);

  a_r2_clean_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en & ~wr_fault & ~(wr_spec & wr_src_nat) |=> !nat_q[$past(wr_addr)] && data_q[$past(wr_addr)] == $past(wr_data));

  a_r5_trap_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en & ~wr_spec & wr_fault |=> nat_q[$past(wr_addr)] == $past(nat_q[wr_addr]) && data_q[$past(wr_addr)] == $past(data_q[wr_addr]));

  a_r7_spec_reader_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rd_spec |-> !exc_o);

  a_r8_port_a_first: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o & rd_a_en & rd_a_nat |-> exc_addr_o == rd_a_addr);

  a_r9_idle_ports_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_a_en & !rd_b_en |-> !exc_o);

endmodule

// File: tb/tb_natreg_file.sv
module tb_natreg_file;
  localparam int NREG = 32;
  localparam int XLEN = 64;
  localparam int AW = $clog2(NREG);

  logic clk = 0, rst_n = 0;
  logic rd_a_en = 0, rd_b_en = 0, rd_spec = 0;
  logic [AW-1:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0, chk_addr = '0;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic rd_a_nat, rd_b_nat;
  logic wr_en = 0, wr_spec = 0, wr_fault = 0, wr_src_nat = 0, chk_en = 0;
  logic exc_o, recover_o;
  logic [AW-1:0] exc_addr_o;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  natreg_file #(.NREG(NREG), .XLEN(XLEN)) dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input longint d, input bit sp, input bit f, input bit sn);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_spec = sp; wr_fault = f; wr_src_nat = sn;
    @(negedge clk);
    wr_en = 0; wr_spec = 0; wr_fault = 0; wr_src_nat = 0;
  endtask

  task automatic read_ports(input bit ea, input int a, input bit eb, input int b, input bit sp);
    rd_a_en = ea; rd_a_addr = AW'(a); rd_b_en = eb; rd_b_addr = AW'(b); rd_spec = sp;
    #1;
  endtask

  task automatic t_reset;
    chk_en = 1; chk_addr = 5;
    read_ports(1, 5, 1, 31, 0);
    check(rd_a_data == 0 && !rd_a_nat, "R1 data/nat", {rd_a_nat, rd_a_data[31:0]}, 0);
    check(!rd_b_nat, "R1 nat b", rd_b_nat, 0);
    check(!exc_o && !recover_o, "R1 outputs", {exc_o, recover_o}, 0);
    chk_en = 0;
  endtask

  task automatic t_clean_write;
    @(negedge clk);
    wr_en = 1; wr_addr = 3; wr_data = 64'hDEAD_BEEF; wr_spec = 0; wr_fault = 0;
    read_ports(1, 3, 0, 0, 0);
    check(rd_a_data == 0, "R11 old data same cycle", rd_a_data, 0);
    @(negedge clk);
    wr_en = 0;
    read_ports(1, 3, 0, 0, 0);
    check(rd_a_data == 64'hDEAD_BEEF && !rd_a_nat, "R2 clean write", rd_a_data, 64'hDEAD_BEEF);
  endtask

  task automatic t_spec_fault;
    do_write(4, 64'h1234, 1, 1, 0);
    read_ports(1, 4, 0, 0, 1);
    check(rd_a_nat && rd_a_data == 0, "R3 poisoned", {rd_a_nat, rd_a_data[31:0]}, 64'h1_0000_0000);
    check(!exc_o && rd_a_nat, "R7 spec read silent", exc_o, 0);
    read_ports(1, 4, 0, 0, 0);
    check(exc_o && exc_addr_o == 4, "R6 normal read raises", {exc_o, exc_addr_o}, {1'b1, 5'd4});
    read_ports(0, 4, 1, 3, 0);
    check(!exc_o, "R9 disabled port", exc_o, 0);
    chk_en = 1; chk_addr = 4; #1;
    check(recover_o, "R10 check poisoned", recover_o, 1);
    chk_addr = 3; #1;
    check(!recover_o, "R10 check clean", recover_o, 0);
    chk_en = 0; read_ports(0, 0, 0, 0, 0);
  endtask

  task automatic t_propagate;
    do_write(5, 64'hAAAA, 1, 0, 1);
    do_write(6, 64'h77, 1, 0, 0);
    read_ports(1, 5, 1, 6, 1);
    check(rd_a_nat && rd_a_data == 0, "R4 poison spreads", rd_a_nat, 1);
    check(!rd_b_nat && rd_b_data == 64'h77, "R4 spec clean write", rd_b_data, 64'h77);
  endtask

  task automatic t_trap;
    do_write(6, 64'h99, 0, 1, 0);
    do_write(5, 64'h88, 0, 1, 0);
    read_ports(1, 6, 1, 5, 1);
    check(rd_a_data == 64'h77 && !rd_a_nat, "R5 trap keeps clean reg", rd_a_data, 64'h77);
    check(rd_b_nat && rd_b_data == 0, "R5 trap keeps poisoned reg", rd_b_nat, 1);
  endtask

  task automatic t_both;
    do_write(8, 64'h1, 1, 1, 0);
    read_ports(1, 8, 1, 5, 0);
    check(exc_o && exc_addr_o == 8, "R8 port A wins", exc_addr_o, 8);
    read_ports(1, 5, 1, 8, 0);
    check(exc_o && exc_addr_o == 5, "R8 port A wins swapped", exc_addr_o, 5);
    read_ports(1, 3, 1, 8, 0);
    check(exc_o && exc_addr_o == 8, "R6 port B raises", exc_addr_o, 8);
    read_ports(0, 0, 0, 0, 0);
  endtask

  task automatic t_clear;
    do_write(4, 64'h55, 0, 0, 0);
    chk_en = 1; chk_addr = 4;
    read_ports(1, 4, 0, 0, 0);
    check(!rd_a_nat && rd_a_data == 64'h55 && !exc_o, "R2 write clears poison", rd_a_data, 64'h55);
    check(!recover_o, "R10 cleared reg no redirect", recover_o, 0);
    chk_en = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_clean_write();
        t_spec_fault();
        t_propagate();
        t_trap();
        t_both();
        t_clear();
      end
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule